// File: doc/BRIEF.md
# Cooperative Round-Robin Context Scheduler

This block decides which of several hardware threads owns a shared processing engine. Every thread has its own register context, so a change of owner saves and restores no state. The owner keeps the engine until it yields of its own accord, and no thread is ever preempted. When it yields, it names a set of completion signals. These are typically the replies to memory requests it has already issued, because a request does not stall the thread that issues it. The thread sleeps until every signal in that set has come back.

Completion signals arrive on a return port that carries a thread number and a signal number. The block latches each one in the pending mask of that thread, whether or not the thread is already waiting for it. A thread is eligible to run when its wait set contains no signal that is still missing. After a yield the block spends one idle cycle on the switch. In that cycle it picks the next eligible thread in round-robin order. The search starts just after the thread that yielded, so that thread has the lowest priority. If nothing is eligible, the engine idles until some thread becomes eligible.

The controller has three states. RUN drives the active thread. SWITCH is the single idle cycle after a yield. IDLE means no thread could be picked. The transitions are: RUN to SWITCH on a yield; RUN to RUN with no yield; SWITCH to RUN, or IDLE to RUN, when an eligible thread exists; SWITCH to IDLE, or IDLE to IDLE, when none exists. Reset enters IDLE with the last-run pointer on the highest thread number.

Top module: `ctx_sched`

## Requirements
- R1: After reset, active_valid is 0 in the first cycle. In the next cycle thread 0 is active, because every thread starts with an empty wait set and the last-run pointer starts on the highest thread.
- R2: While active_valid is 1 and yield_valid is 0, the next cycle has the same active_tid with active_valid still 1, whatever signals arrive.
- R3: A yield sampled while a thread is active gives active_valid 0 in the following cycle. This is the one idle cycle of a context switch.
- R4: At a switch the next thread is the first eligible one in the order tid+1, tid+2, ... modulo the thread count, where tid is the thread that last ran. That thread itself is tried last.
- R5: A thread that has yielded is not made active until every signal whose bit is set in its yield_mask has been received. Bit n of yield_mask stands for signal number n.
- R6: A signal returned before its thread waits on it stays latched. A later wait that names it completes without a new return. Pending signals that are outside the wait set survive a dispatch.
- R7: A signal returned for the yielding thread in the same cycle as its yield counts toward that wait.
- R8: When no thread is eligible, active_valid stays 0. A signal that makes a thread eligible, presented in cycle T, makes that thread active in cycle T+2.
- R9: Dispatching a thread consumes the pending bits named in its wait set. A return of the same signal in the dispatch cycle stays latched.
- R10: yield_valid and yield_mask are ignored while active_valid is 0.
- R11: A return with sig_valid 1 sets bit sig_num in the pending mask of thread sig_tid only.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| yield_valid | input | 1 | The active thread gives up the engine this cycle |
| yield_mask | input | NUM_SIGS | Signals the yielding thread will wait for, one bit per signal number |
| sig_valid | input | 1 | A completion signal is returned this cycle |
| sig_tid | input | clog2(NUM_THREADS) | Thread that owns the returned signal |
| sig_num | input | clog2(NUM_SIGS) | Number of the returned signal |
| active_valid | output | 1 | A thread owns the engine this cycle |
| active_tid | output | clog2(NUM_THREADS) | Thread that owns the engine |

## Verification
Two collisions matter most. The first is a signal return that lands in the same cycle as the yield that waits on it. The second is a return that lands in the same cycle as the dispatch that consumes the pending bits. The bench drives the first by yielding and returning the awaited signal in one cycle, and expects the thread back two cycles later. It drives the second by returning a signal again in the wake-up cycle, and expects the next wait on it to complete at once. A cycle-level model in the bench also runs under a long pseudo-random mix of yields and returns, where these collisions arise many times, and every output cycle is compared with that model.

// File: rtl/ctx_sched_pkg.sv
package ctx_sched_pkg;

    typedef enum logic [1:0] {
        SCH_IDLE   = 2'd0,
        SCH_RUN    = 2'd1,
        SCH_SWITCH = 2'd2
    } sch_state_e;

endpackage

// File: rtl/ctx_thread_slot.sv
module ctx_thread_slot #(
    parameter int NUM_SIGS = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                park_i,
    input  logic [NUM_SIGS-1:0] park_mask_i,
    input  logic                sig_hit_i,
    input  logic [NUM_SIGS-1:0] sig_bits_i,
    input  logic                launch_i,
    output logic                eligible_o
);

    logic [NUM_SIGS-1:0] wait_q;
    logic [NUM_SIGS-1:0] pend_q;
    logic [NUM_SIGS-1:0] pend_set;
    logic [NUM_SIGS-1:0] pend_clr;

    assign eligible_o = ~|(wait_q & ~pend_q);
    assign pend_set   = sig_hit_i ? sig_bits_i : '0;
    assign pend_clr   = launch_i  ? wait_q     : '0;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wait_q <= '0;
            pend_q <= '0;
        end else begin
            if (park_i) begin
                wait_q <= park_mask_i;
            end else if (launch_i) begin
                wait_q <= '0;
            end
            pend_q <= (pend_q & ~pend_clr) | pend_set;
        end
    end

    // A dispatch is only granted to a slot whose wait set is satisfied (R5)
    assert_launch_ready_R5: assert property (@(posedge clk) disable iff (!rst_n)
        launch_i |-> eligible_o);

    // A returned signal is held in the pending mask one cycle later (R6, R9)
    assert_sig_latched_R6: assert property (@(posedge clk) disable iff (!rst_n)
        sig_hit_i |=> ((pend_q & $past(sig_bits_i)) == $past(sig_bits_i)));

    // Yield and dispatch never coincide on one slot
    assert_no_park_launch_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !(park_i && launch_i));

endmodule

// File: rtl/ctx_rr_pick.sv
module ctx_rr_pick #(
    parameter int NUM_THREADS = 8
) (
    input  logic [NUM_THREADS-1:0]         elig_i,
    input  logic [$clog2(NUM_THREADS)-1:0] last_i,
    output logic                           found_o,
    output logic [$clog2(NUM_THREADS)-1:0] pick_o,
    output logic [NUM_THREADS-1:0]         grant_o
);

    localparam int TID_W = $clog2(NUM_THREADS);

    always_comb begin
        found_o = 1'b0;
        pick_o  = '0;
        // walk from farthest to nearest so the nearest eligible thread wins
        for (int k = NUM_THREADS - 1; k >= 0; k--) begin
            int idx;
            idx = (int'(last_i) + 1 + k) % NUM_THREADS;
            if (elig_i[idx]) begin
                found_o = 1'b1;
                pick_o  = TID_W'(idx);
            end
        end
    end

    always_comb begin
        grant_o = '0;
        if (found_o) begin
            grant_o[pick_o] = 1'b1;
        end
    end

endmodule

// File: rtl/ctx_sched.sv
module ctx_sched #(
    parameter int NUM_THREADS = 8,
    parameter int NUM_SIGS    = 8
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           yield_valid,
    input  logic [NUM_SIGS-1:0]            yield_mask,
    input  logic                           sig_valid,
    input  logic [$clog2(NUM_THREADS)-1:0] sig_tid,
    input  logic [$clog2(NUM_SIGS)-1:0]    sig_num,
    output logic                           active_valid,
    output logic [$clog2(NUM_THREADS)-1:0] active_tid
);

    import ctx_sched_pkg::*;

    localparam int TID_W = $clog2(NUM_THREADS);

    sch_state_e             state_q, state_d;
    logic [TID_W-1:0]       cur_q;
    logic [NUM_THREADS-1:0] elig;
    logic [NUM_THREADS-1:0] grant;
    logic [NUM_THREADS-1:0] launch;
    logic                   found;
    logic [TID_W-1:0]       pick;
    logic                   picking;
    logic                   yield_take;
    logic [NUM_SIGS-1:0]    sig_onehot;

    assign picking    = (state_q != SCH_RUN);
    assign yield_take = (state_q == SCH_RUN) && yield_valid;
    assign sig_onehot = NUM_SIGS'(1) << sig_num;
    assign launch     = picking ? grant : '0;

    ctx_rr_pick #(.NUM_THREADS(NUM_THREADS)) u_pick (
        .elig_i  (elig),
        .last_i  (cur_q),
        .found_o (found),
        .pick_o  (pick),
        .grant_o (grant)
    );

    for (genvar t = 0; t < NUM_THREADS; t++) begin : g_slot
        ctx_thread_slot #(.NUM_SIGS(NUM_SIGS)) u_slot (
            .clk         (clk),
            .rst_n       (rst_n),
            .park_i      (yield_take && (cur_q == TID_W'(t))),
            .park_mask_i (yield_mask),
            .sig_hit_i   (sig_valid && (sig_tid == TID_W'(t))),
            .sig_bits_i  (sig_onehot),
            .launch_i    (launch[t]),
            .eligible_o  (elig[t])
        );
    end

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            SCH_RUN:    state_d = yield_valid ? SCH_SWITCH : SCH_RUN;
            SCH_SWITCH: state_d = found ? SCH_RUN : SCH_IDLE;
            SCH_IDLE:   state_d = found ? SCH_RUN : SCH_IDLE;
            default:    state_d = SCH_IDLE;
        endcase
    end

    // state register and last-run pointer
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= SCH_IDLE;
            cur_q   <= TID_W'(NUM_THREADS - 1);
        end else begin
            state_q <= state_d;
            if (picking && found) begin
                cur_q <= pick;
            end
        end
    end

    // outputs
    always_comb begin
        active_valid = (state_q == SCH_RUN);
        active_tid   = cur_q;
    end

    assert_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (active_valid && !yield_valid) |=> (active_valid && $stable(active_tid)));

    assert_gap_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (active_valid && yield_valid) |=> !active_valid);

    assert_grant_onehot_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(grant));

    assert_resume_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!active_valid && (|elig)) |=> active_valid);

    assert_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!active_valid && !(|elig)) |=> !active_valid);

endmodule

// File: tb/ctx_sched_tb_top.sv
module ctx_sched_tb_top;

    localparam int N  = 8;
    localparam int NS = 8;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       yield_valid = 1'b0;
    logic [7:0] yield_mask = '0;
    logic       sig_valid = 1'b0;
    logic [2:0] sig_tid = '0;
    logic [2:0] sig_num = '0;
    logic       active_valid;
    logic [2:0] active_tid;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    ctx_sched #(.NUM_THREADS(N), .NUM_SIGS(NS)) dut_i (
        .clk(clk), .rst_n(rst_n),
        .yield_valid(yield_valid), .yield_mask(yield_mask),
        .sig_valid(sig_valid), .sig_tid(sig_tid), .sig_num(sig_num),
        .active_valid(active_valid), .active_tid(active_tid)
    );

    // cycle model built from the requirements: 0 idle, 1 run, 2 switch
    int         m_state;
    int         m_cur;
    logic [7:0] m_wait [N];
    logic [7:0] m_pend [N];

    task automatic model_reset();
        m_state = 0;
        m_cur   = N - 1;
        for (int i = 0; i < N; i++) begin
            m_wait[i] = '0;
            m_pend[i] = '0;
        end
    endtask

    task automatic model_step(input bit yv, input logic [7:0] wm,
                              input bit sv, input int st, input int sn);
        logic [7:0] clr [N];
        int p;
        for (int i = 0; i < N; i++) clr[i] = '0;
        if (m_state == 1) begin
            if (yv) begin
                m_wait[m_cur] = wm;
                m_state = 2;
            end
        end else begin
            p = -1;
            for (int k = 1; k <= N; k++) begin
                int c;
                c = (m_cur + k) % N;
                if (p < 0 && ((m_wait[c] & ~m_pend[c]) == 0)) p = c;
            end
            if (p >= 0) begin
                clr[p]    = m_wait[p];
                m_wait[p] = '0;
                m_cur     = p;
                m_state   = 1;
            end else begin
                m_state = 0;
            end
        end
        for (int i = 0; i < N; i++) begin
            m_pend[i] = m_pend[i] & ~clr[i];
            if (sv && st == i) m_pend[i][sn] = 1'b1;
        end
    endtask

    task automatic check_model(input string tag);
        bit ev;
        ev = (m_state == 1);
        n_chk++;
        if (active_valid !== ev || (ev && active_tid !== 3'(m_cur))) begin
            n_bad++;
            $display("FAIL %s model: valid=%0b tid=%0d expected valid=%0b tid=%0d",
                     tag, active_valid, active_tid, ev, m_cur);
        end
    endtask

    task automatic check_lit(input bit ev, input int et, input string tag);
        n_chk++;
        if (active_valid !== ev || (ev && active_tid !== 3'(et))) begin
            n_bad++;
            $display("FAIL %s: valid=%0b tid=%0d expected valid=%0b tid=%0d",
                     tag, active_valid, active_tid, ev, et);
        end
    endtask

    // drive one cycle of stimulus, then sample at the following falling edge
    task automatic tick(input bit yv, input logic [7:0] wm,
                        input bit sv, input int st, input int sn, input string tag);
        yield_valid = yv;
        yield_mask  = wm;
        sig_valid   = sv;
        sig_tid     = 3'(st);
        sig_num     = 3'(sn);
        model_step(yv, wm, sv, st, sn);
        @(negedge clk);
        check_model(tag);
    endtask

    task automatic idle_tick(input string tag);
        tick(1'b0, 8'h00, 1'b0, 0, 0, tag);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_bad++;
        n_chk++;
        $display("FAIL watchdog: run did not complete, expected completion");
        finish_run();
    end

    initial begin
        logic [31:0] lfsr;
        model_reset();
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        check_lit(1'b0, 0, "R1 first cycle");
        idle_tick("R1");
        check_lit(1'b1, 0, "R1 thread 0 first");

        // every thread in turn waits on its own signal number
        for (int t = 0; t < N; t++) begin
            tick(1'b1, 8'(1 << t), 1'b0, 0, 0, "R3");
            check_lit(1'b0, 0, "R3 switch gap");
            idle_tick("R4");
            if (t < N - 1) check_lit(1'b1, t + 1, "R4 next in order");
            else           check_lit(1'b0, 0, "R8 none eligible");
        end
        idle_tick("R8");
        check_lit(1'b0, 0, "R8 stays idle");

        // wake thread 5 with signal 5
        tick(1'b0, 8'h00, 1'b1, 5, 5, "R11");
        check_lit(1'b0, 0, "R8 decision cycle");
        idle_tick("R8");
        check_lit(1'b1, 5, "R11 R8 resume at T+2");

        // wait on signals 2 and 3
        tick(1'b1, 8'h0C, 1'b0, 0, 0, "R5");
        idle_tick("R5");
        check_lit(1'b0, 0, "R5 nothing back");
        tick(1'b0, 8'h00, 1'b1, 5, 2, "R5");
        idle_tick("R5");
        check_lit(1'b0, 0, "R5 one of two back");
        tick(1'b0, 8'h00, 1'b1, 5, 3, "R5");
        idle_tick("R5");
        check_lit(1'b1, 5, "R5 all back");

        // early signal for thread 3, then its wake-up; no preemption of 5
        tick(1'b0, 8'h00, 1'b1, 3, 6, "R2");
        check_lit(1'b1, 5, "R2 hold");
        tick(1'b0, 8'h00, 1'b1, 3, 3, "R2");
        check_lit(1'b1, 5, "R2 hold after wake");
        tick(1'b1, 8'h80, 1'b0, 0, 0, "R3");
        idle_tick("R4");
        check_lit(1'b1, 3, "R4 woken thread");
        tick(1'b1, 8'h40, 1'b0, 0, 0, "R6");
        idle_tick("R6");
        check_lit(1'b1, 3, "R6 early signal latched");

        // return in the same cycle as the yield
        tick(1'b1, 8'h02, 1'b1, 3, 1, "R7");
        idle_tick("R7");
        check_lit(1'b1, 3, "R7 same-cycle return");

        // consumption on dispatch, and a return in the dispatch cycle
        tick(1'b1, 8'h40, 1'b0, 0, 0, "R9");
        idle_tick("R9");
        check_lit(1'b0, 0, "R9 consumed at dispatch");
        tick(1'b0, 8'h00, 1'b1, 3, 6, "R9");
        tick(1'b0, 8'h00, 1'b1, 3, 6, "R9");
        check_lit(1'b1, 3, "R9 wake");
        tick(1'b1, 8'h40, 1'b0, 0, 0, "R9");
        idle_tick("R9");
        check_lit(1'b1, 3, "R9 dispatch-cycle return kept");

        // yield while no thread is active
        tick(1'b1, 8'h00, 1'b0, 0, 0, "R10");
        tick(1'b1, 8'hFF, 1'b0, 0, 0, "R10");
        check_lit(1'b1, 3, "R10 yield in switch ignored");
        for (int i = 0; i < 3; i++) begin
            idle_tick("R10");
            check_lit(1'b1, 3, "R10 still running");
        end

        // pseudo-random sweep against the model (R2 R4 R5 R6 R7 R8 R9)
        lfsr = 32'hACE1_2357;
        for (int c = 0; c < 6000; c++) begin
            bit         yv;
            logic [7:0] wm;
            lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
            yv = (lfsr[1:0] == 2'b00);
            wm = lfsr[9:2] & lfsr[17:10] & (lfsr[25:18] | lfsr[5:0]);
            tick(yv, wm, lfsr[26], int'(lfsr[29:27]), int'({lfsr[31:30], lfsr[3]}), "R4 sweep");
        end

        finish_run();
    end

endmodule